// File: doc/BRIEF.md
# Serial Pattern Recognizer

The recognizer watches a one-bit serial stream and flags every point where the four most recently accepted samples, from oldest to newest, read 1, 0, 0, 1. Accepted samples enter a short cascade of storage stages. Each accepted sample moves the earlier samples one stage further back. A purely combinational compare on the stored samples drives the match flag. There is no state machine and no output register.

The stream side is a valid-qualified input. A sample is accepted on a rising clock edge only when `bit_valid` is high. The block never applies back-pressure: it has no ready signal and accepts one sample on every cycle that `bit_valid` is high. When `bit_valid` is low, the value on `bit_in` is ignored and the stored history stays as it is. Occurrences that overlap are all reported, so a shared 1 can end one match and begin the next.

The history depth and the target pattern are elaboration parameters. Their defaults are four stages and the pattern 1001.

Top module: `spr_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `match` is 0 and all history stages hold 0.
- R2: On each rising edge with `bit_valid` high, `bit_in` enters the newest stage and every other stage takes the value of its newer neighbour.
- R3: `match` is 1 exactly when the history holds, oldest to newest, 1,0,0,1. Any other contents (for example 1011, 1000, 0001, 1101) give 0.
- R4: `match` rises in the same cycle that the final 1 of the pattern is registered. It is read just after that edge and does not wait a further clock.
- R5: On a rising edge with `bit_valid` low, the history and `match` do not change, whatever the value of `bit_in`.
- R6: Overlapping occurrences are reported. The accepted input 1,0,0,1,0,0,1 gives `match` high after the 4th and after the 7th sample, and low after each of the others.
- R7: After reset, `match` stays 0 until at least four samples have been accepted.
- R8: Cycles with `bit_valid` low inserted between pattern bits do not prevent detection, and they do not inject the `bit_in` values present during those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the history |
| bit_in | input | 1 | Serial data sample |
| bit_valid | input | 1 | Sample qualifier; high accepts `bit_in` on this edge |
| match | output | 1 | High while the stored history equals the pattern |

## Verification
The assertions assume that `bit_in` and `bit_valid` are settled and free of X on every rising edge while reset is released. They also assume that reset is released while no sample is being offered. The bench meets both conditions: it changes the inputs only on falling edges, and it holds `bit_valid` low during reset and on the first edge after reset. The checker counts accepted samples on its own. From that count and the last accepted bit it judges fill, hold and non-repetition of the flag, so it does not rely on the design's stored state.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned SPR_DEPTH = 4;
  // Most significant bit is compared with the oldest stored sample.
  localparam logic [SPR_DEPTH-1:0] SPR_PATTERN = 4'b1001;
endpackage

// File: rtl/spr_stage.sv
module spr_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (shift_en) q <= d;
  end
endmodule

// File: rtl/spr_history.sv
module spr_history #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [DEPTH-1:0] hist
);
  // hist[0] is the newest sample, hist[DEPTH-1] the oldest.
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic d_in;
    if (g == 0) begin : g_head
      assign d_in = bit_in;
    end else begin : g_body
      assign d_in = hist[g-1];
    end
    spr_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .d        (d_in),
      .q        (hist[g])
    );
  end
endmodule

// File: rtl/spr_compare.sv
module spr_compare #(
  parameter int unsigned           DEPTH   = 4,
  parameter logic [DEPTH-1:0]      PATTERN = 4'b1001
) (
  input  logic [DEPTH-1:0] hist,
  output logic             hit
);
  logic [DEPTH-1:0] bit_eq;
  for (genvar g = 0; g < DEPTH; g++) begin : g_eq
    assign bit_eq[g] = ~(hist[g] ^ PATTERN[g]);
  end
  assign hit = &bit_eq;
endmodule

// File: rtl/spr_top.sv
module spr_top
  import spr_pkg::*;
#(
  parameter int unsigned      DEPTH   = SPR_DEPTH,
  parameter logic [DEPTH-1:0] PATTERN = SPR_PATTERN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_valid,
  output logic match
);
  logic [DEPTH-1:0] hist;

  spr_history #(.DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_valid),
    .bit_in   (bit_in),
    .hist     (hist)
  );

  spr_compare #(.DEPTH(DEPTH), .PATTERN(PATTERN)) u_cmp (
    .hist (hist),
    .hit  (match)
  );
endmodule

// File: rtl/spr_top_chk.sv
module spr_top_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bit_in,
  input logic bit_valid,
  input logic match
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  logic [CW-1:0] fill_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_cnt <= '0;
    else if (bit_valid && fill_cnt != CW'(DEPTH)) fill_cnt <= fill_cnt + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !match); // R1

  AST_NEWEST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(bit_valid)) |-> $past(bit_in)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(match)); // R5

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (match && bit_valid) |=> !match); // R6

  AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (fill_cnt == CW'(DEPTH))); // R7
endmodule

bind spr_top spr_top_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_in    (bit_in),
  .bit_valid (bit_valid),
  .match     (match)
);

// File: tb/spr_top_bench.sv
`timescale 1ns/1ps
module spr_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic bit_in = 1'b0;
  logic bit_valid = 1'b0;
  logic match;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'b0000;   // bit 3 oldest, bit 0 newest

  always #5 clk = ~clk;

  spr_top u_spr_top (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid), .match(match)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s match actual %b expected %b (model %b)", req, act, exp, model);
    end
  endtask

  // Offer one sample, then sample match just after the registering edge.
  task automatic step(input logic b, input logic v, input string req);
    @(negedge clk);
    bit_in = b; bit_valid = v;
    @(posedge clk);
    if (v) model = {model[2:0], b};
    #2;
    chk(req, match, model == 4'b1001);
  endtask

  task automatic do_reset();
    @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b1;
    rst_n = 1'b0;
    model = 4'b0000;
    #3;
    chk("R1 during reset", match, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release", match, 1'b0);
  endtask

  task automatic t_single();
    do_reset();
    step(1, 1, "R2"); step(0, 1, "R2"); step(0, 1, "R2");
    step(1, 1, "R4 final bit");
    chk("R4 same cycle", match, 1'b1);
    step(1, 1, "R3 after match");
  endtask

  task automatic t_fill();
    do_reset();
    step(0, 1, "R7"); step(0, 1, "R7"); step(1, 1, "R7");
    chk("R7 three samples", match, 1'b0);
  endtask

  task automatic t_near_miss();
    logic [3:0] pats [4] = '{4'b1011, 4'b1000, 4'b0001, 4'b1101};
    foreach (pats[i]) begin
      do_reset();
      for (int k = 3; k >= 0; k--) step(pats[i][k], 1, "R3 near miss");
      chk("R3 no hit", match, 1'b0);
    end
  endtask

  task automatic t_overlap();
    logic [6:0] s = 7'b1001001;
    int hits = 0;
    do_reset();
    for (int k = 6; k >= 0; k--) begin
      step(s[k], 1, "R6");
      if (match) hits++;
      if (k == 3 || k == 0) chk("R6 expected hit", match, 1'b1);
    end
    checks++;
    if (hits != 2) begin
      errors++;
      $display("FAIL R6 hit count actual %0d expected 2", hits);
    end
  endtask

  task automatic t_hold();
    do_reset();
    step(1, 1, "R5"); step(0, 1, "R5"); step(0, 1, "R5"); step(1, 1, "R5");
    for (int k = 0; k < 3; k++) step(k[0], 0, "R5 hold high");
    chk("R5 still matched", match, 1'b1);
    step(0, 1, "R5 resume");
    chk("R5 dropped after shift", match, 1'b0);
  endtask

  task automatic t_gaps();
    do_reset();
    step(1, 1, "R8"); step(1, 0, "R8 gap");
    step(0, 1, "R8"); step(1, 0, "R8 gap"); step(1, 0, "R8 gap");
    step(0, 1, "R8"); step(0, 0, "R8 gap");
    step(1, 1, "R8");
    chk("R8 detected across gaps", match, 1'b1);
  endtask

  task automatic t_stream();
    logic [7:0] lfsr = 8'hA5;
    do_reset();
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1] | lfsr[2], "R2 R3 stream");
    end
  endtask

  initial begin
    fork
      begin
        #2 rst_n = 1'b0;
        t_single();
        t_fill();
        t_near_miss();
        t_overlap();
        t_hold();
        t_gaps();
        t_stream();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule